// File: doc/BRIEF.md
# Radix-40 Character Stream Packer

This block takes a stream of 8-bit ASCII characters and packs them, three at a time, into 16-bit words in base-40 form. Each beat on the input carries either one character or an end-of-string marker. Every character is first translated into a code from 0 to 39. Three codes C1, C2 and C3 then fold into one word as ((C1*40)+C2)*40+C3. When a string ends part-way through a group, the group is left-justified and its missing trailing positions are padded with the space code.

A caller can bypass the character map and insert an explicit code on any beat. This is the only way to reach code 29, which has no printable character. A character outside the legal set, or a raw code above 39, is replaced by code 0. It also raises an error flag that travels with the word holding it. The result sits in a single output register with a valid/ready handshake, and the input stalls while that register holds a word nobody has taken yet.

Top module: `r40_stream_packer`

## Requirements
- R1: Characters map to codes (decimal) as follows: space is 0; 'A' to 'Z' are 1 to 26; '$' is 27; '.' is 28; '0' to '9' are 30 to 39.
- R2: A full group of codes C1, C2, C3 produces out_word = ((C1*40)+C2)*40+C3. The largest result, 63999, is represented without overflow.
- R3: When the beat carrying the third code of a group is accepted on a clock edge, out_valid is high from that edge on, with the group's word.
- R4: When an end beat (in_eos=1) is accepted while one or two codes are pending, the next word is those codes left-justified with code 0 in the missing positions. The word is presented from that same edge on.
- R5: An end beat accepted with no code pending (an empty string, or a length that is a multiple of three) produces no word.
- R6: Any character not listed in R1, lower-case letters included, is packed as code 0. out_err is high together with the word that contains it, and low for words with only legal codes.
- R7: With in_raw=1 the beat's code is taken directly from in_data[5:0]. Values 0 to 39 are legal, so 'A', 'B', raw 29 packs to 3255 octal. A raw value above 39 is handled as in R6.
- R8: While out_valid=1 and out_ready=0, in_ready is 0, and out_word and out_err hold their values.
- R9: After reset, out_valid is 0, in_ready is 1, and any partly collected group is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Packer can take a beat |
| in_data | input | 8 | ASCII character, or raw code in bits 5:0 |
| in_raw | input | 1 | Beat carries a raw code instead of a character |
| in_eos | input | 1 | Beat is an end-of-string marker; in_data is ignored |
| out_valid | output | 1 | Packed word available |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 16 | Packed base-40 word |
| out_err | output | 1 | Word contains at least one illegal input |

## Verification
The bench builds the packer with its default parameters: a group of three, an 11-bit partial accumulator, 16-bit words and the raw-code path enabled. Because the raw path is present, the otherwise unreachable code 29 and out-of-range raw values can be tested. Because the word width is exactly 16 bits, the all-'9' group that yields 63999 is a true boundary test for overflow. The stimulus covers groups of one, two and three codes, a string that spills into a second word, an empty string, reset in the middle of a group, and a held output under backpressure.

// File: rtl/r40_pkg.sv
package r40_pkg;

   localparam int unsigned R40_RADIX   = 40;
   localparam int unsigned R40_CODE_W  = 6;

   localparam int unsigned R40_C_SPACE  = 0;
   localparam int unsigned R40_C_LETTER = 1;   // code of 'A'
   localparam int unsigned R40_C_DOLLAR = 27;
   localparam int unsigned R40_C_DOT    = 28;
   localparam int unsigned R40_C_DIGIT  = 30;  // code of '0'

   typedef struct packed {
      logic [R40_CODE_W-1:0] code;
      logic                  bad;
   } r40_sym_t;

endpackage

// File: rtl/r40_char_map.sv
module r40_char_map
   import r40_pkg::*;
#(
   parameter int unsigned CHAR_W = 8,
   parameter bit          RAW_EN = 1'b1
)(
   input  logic [CHAR_W-1:0] chr,
   input  logic              raw,
   output r40_sym_t          sym
);

   r40_sym_t map_sym;

   always_comb begin
      map_sym.code = '0;
      map_sym.bad  = 1'b0;
      if (chr == CHAR_W'(8'h20)) begin
         map_sym.code = R40_CODE_W'(R40_C_SPACE);
      end else if (chr >= CHAR_W'(8'h41) && chr <= CHAR_W'(8'h5A)) begin
         map_sym.code = R40_CODE_W'(chr - CHAR_W'(8'h41) + CHAR_W'(R40_C_LETTER));
      end else if (chr == CHAR_W'(8'h24)) begin
         map_sym.code = R40_CODE_W'(R40_C_DOLLAR);
      end else if (chr == CHAR_W'(8'h2E)) begin
         map_sym.code = R40_CODE_W'(R40_C_DOT);
      end else if (chr >= CHAR_W'(8'h30) && chr <= CHAR_W'(8'h39)) begin
         map_sym.code = R40_CODE_W'(chr - CHAR_W'(8'h30) + CHAR_W'(R40_C_DIGIT));
      end else begin
         map_sym.bad  = 1'b1;
      end
   end

   generate
      if (RAW_EN) begin : g_raw
         r40_sym_t raw_sym;
         always_comb begin
            if (chr < CHAR_W'(R40_RADIX)) begin
               raw_sym.code = R40_CODE_W'(chr);
               raw_sym.bad  = 1'b0;
            end else begin
               raw_sym.code = '0;
               raw_sym.bad  = 1'b1;
            end
         end
         assign sym = raw ? raw_sym : map_sym;
      end else begin : g_noraw
         logic raw_unused;
         assign raw_unused = raw;
         assign sym        = map_sym;
      end
   endgenerate

endmodule

// File: rtl/r40_group_acc.sv
module r40_group_acc
   import r40_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ACC_W  = 11,
   parameter int unsigned GROUP  = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  r40_sym_t          sym,
   input  logic              eos,
   output logic              emit,
   output logic [WORD_W-1:0] word,
   output logic              word_err
);

   localparam int unsigned CNT_W = $clog2(GROUP + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP - 1);

   logic [ACC_W-1:0]  acc_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              err_q;
   logic [WORD_W-1:0] full_w;
   logic [WORD_W-1:0] pad_w;
   logic              closes;

   function automatic logic [WORD_W-1:0] rad_pow(input logic [CNT_W-1:0] n);
      logic [WORD_W-1:0] p;
      p = WORD_W'(1);
      for (int i = 0; i < GROUP; i++) begin
         if (i < int'(n)) p = p * WORD_W'(R40_RADIX);
      end
      return p;
   endfunction

   assign full_w = WORD_W'(acc_q) * WORD_W'(R40_RADIX) + WORD_W'(sym.code);
   assign pad_w  = WORD_W'(acc_q) * rad_pow(CNT_W'(GROUP) - cnt_q);
   assign closes = step && (cnt_q == LAST);

   assign emit     = closes || (eos && (cnt_q != '0));
   assign word     = step ? full_w : pad_w;
   assign word_err = step ? (err_q | sym.bad) : err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         cnt_q <= '0;
         err_q <= 1'b0;
      end else if (closes || eos) begin
         acc_q <= '0;
         cnt_q <= '0;
         err_q <= 1'b0;
      end else if (step) begin
         acc_q <= ACC_W'(full_w);
         cnt_q <= cnt_q + CNT_W'(1);
         err_q <= err_q | sym.bad;
      end
   end

endmodule

// File: rtl/r40_out_reg.sv
module r40_out_reg #(
   parameter int unsigned WORD_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   input  logic              err_in,
   input  logic              take,
   output logic              valid,
   output logic [WORD_W-1:0] word_out,
   output logic              err_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid    <= 1'b0;
         word_out <= '0;
         err_out  <= 1'b0;
      end else if (load) begin
         valid    <= 1'b1;
         word_out <= word_in;
         err_out  <= err_in;
      end else if (take) begin
         valid    <= 1'b0;
      end
   end

endmodule

// File: rtl/r40_stream_packer.sv
module r40_stream_packer
   import r40_pkg::*;
#(
   parameter int unsigned CHAR_W = 8,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ACC_W  = 11,
   parameter int unsigned GROUP  = 3,
   parameter bit          RAW_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CHAR_W-1:0] in_data,
   input  logic              in_raw,
   input  logic              in_eos,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_word,
   output logic              out_err
);

   function automatic longint unsigned pow_r(input int unsigned n);
      longint unsigned p = 1;
      for (int unsigned i = 0; i < n; i++) p = p * R40_RADIX;
      return p;
   endfunction

   localparam longint unsigned WORD_SPAN = pow_r(GROUP);
   localparam longint unsigned ACC_SPAN  = pow_r(GROUP - 1);

   generate
      if (GROUP < 2) begin : g_chk_group
         $error("GROUP must be at least 2");
      end
      if (CHAR_W < R40_CODE_W) begin : g_chk_char
         $error("CHAR_W must hold a raw code");
      end
      if (WORD_SPAN > (64'd1 << WORD_W)) begin : g_chk_word
         $error("WORD_W too narrow for GROUP codes");
      end
      if (ACC_SPAN > (64'd1 << ACC_W)) begin : g_chk_acc
         $error("ACC_W too narrow for a partial group");
      end
   endgenerate

   r40_sym_t          sym;
   logic              step, eos_acc, emit, w_err;
   logic [WORD_W-1:0] w_val;

   assign in_ready = !out_valid || out_ready;
   assign step     = in_valid && in_ready && !in_eos;
   assign eos_acc  = in_valid && in_ready && in_eos;

   r40_char_map #(
      .CHAR_W (CHAR_W),
      .RAW_EN (RAW_EN)
   ) u_map (
      .chr (in_data),
      .raw (in_raw),
      .sym (sym)
   );

   r40_group_acc #(
      .WORD_W (WORD_W),
      .ACC_W  (ACC_W),
      .GROUP  (GROUP)
   ) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .sym      (sym),
      .eos      (eos_acc),
      .emit     (emit),
      .word     (w_val),
      .word_err (w_err)
   );

   r40_out_reg #(
      .WORD_W (WORD_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (emit),
      .word_in  (w_val),
      .err_in   (w_err),
      .take     (out_ready),
      .valid    (out_valid),
      .word_out (out_word),
      .err_out  (out_err)
   );

endmodule

// File: rtl/r40_stream_packer_chk.sv
module r40_stream_packer_chk #(
   parameter int unsigned CHAR_W = 8,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned GROUP  = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [CHAR_W-1:0] in_data,
   input logic              in_raw,
   input logic              in_eos,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_word,
   input logic              out_err
);

   localparam int unsigned CNT_W = $clog2(GROUP + 1);

   logic [CNT_W-1:0] seen_q;
   logic             acc_chr, acc_end;

   assign acc_chr = in_valid && in_ready && !in_eos;
   assign acc_end = in_valid && in_ready && in_eos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   seen_q <= '0;
      else if (acc_end)                             seen_q <= '0;
      else if (acc_chr && seen_q == CNT_W'(GROUP-1)) seen_q <= '0;
      else if (acc_chr)                             seen_q <= seen_q + CNT_W'(1);
   end

   // R8: a stalled word stays put
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_err));

   // R8: no input while the word is pending
   a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   // R2: result never exceeds the base-40 range of a full group
   a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_word <= WORD_W'(63999));

   // R3: third code accepted, word follows
   a_r3_full_emit: assert property (@(posedge clk) disable iff (!rst_n)
      acc_chr && seen_q == CNT_W'(GROUP-1) |=> out_valid);

   // R4: end of a partial group emits a word
   a_r4_pad_emit: assert property (@(posedge clk) disable iff (!rst_n)
      acc_end && seen_q != '0 |=> out_valid);

   // R5: end with nothing pending emits nothing
   a_r5_empty: assert property (@(posedge clk) disable iff (!rst_n)
      acc_end && seen_q == '0 |=> !out_valid);

   // R9: reset clears the output
   a_r9_reset: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

   logic unused_ok;
   assign unused_ok = ^{in_data, in_raw};

endmodule

bind r40_stream_packer r40_stream_packer_chk #(
   .CHAR_W (CHAR_W),
   .WORD_W (WORD_W),
   .GROUP  (GROUP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_data   (in_data),
   .in_raw    (in_raw),
   .in_eos    (in_eos),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_word  (out_word),
   .out_err   (out_err)
);

// File: tb/r40_stream_packer_tb.sv
module r40_stream_packer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 11;

   // strings are right-justified; length gives the count of characters
   localparam logic [47:0] V_STR [NV] = '{
      48'("ABC"), 48'("AB"), 48'("ABCD"), 48'("ABCDEF"), 48'("Z9."),
      48'("$0 "), 48'("999"), 48'("X"), 48'("AbC"), 48'("#"), 48'("ABCDb")};
   localparam int V_LEN [NV] = '{3, 2, 4, 6, 3, 3, 3, 1, 3, 1, 5};
   localparam int V_NW  [NV] = '{1, 1, 2, 2, 1, 1, 1, 1, 1, 1, 2};
   localparam logic [15:0] V_W0 [NV] = '{
      16'h0693, 16'h0690, 16'h0693, 16'h0693, 16'hA8B4,
      16'hAD70, 16'hF9FF, 16'h9600, 16'h0643, 16'h0000, 16'h0693};
   localparam logic [15:0] V_W1 [NV] = '{
      16'h0, 16'h0, 16'h1900, 16'h19CE, 16'h0,
      16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h1900};
   localparam logic V_E0 [NV] = '{0,0,0,0,0,0,0,0,1,1,0};
   localparam logic V_E1 [NV] = '{0,0,0,0,0,0,0,0,0,0,1};
   localparam string V_TAG [NV] = '{
      "R2", "R4", "R4", "R3", "R1", "R1", "R2", "R4", "R6", "R6", "R6"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = '0;
   logic        in_raw = 1'b0;
   logic        in_eos = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [15:0] out_word;
   logic        out_err;

   int nchk = 0;
   int nfail = 0;
   int tot = 0;
   int cycles = 0;
   logic [15:0] cap_w [64];
   logic        cap_e [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   r40_stream_packer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_raw    (in_raw),
      .in_eos    (in_eos),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_word  (out_word),
      .out_err   (out_err)
   );

   // record every word handed over to the consumer
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         cap_w[tot % 64] = out_word;
         cap_e[tot % 64] = out_err;
         tot = tot + 1;
      end
   end

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (cycles > 20000) begin
         nchk = nchk + 1;
         nfail = nfail + 1;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk = nchk + 1;
      if (!ok) begin
         nfail = nfail + 1;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one beat, held until accepted; starts and ends just after a rising edge
   task automatic beat(input logic [7:0] d, input logic raw, input logic eos);
      in_valid = 1'b1;
      in_data  = d;
      in_raw   = raw;
      in_eos   = eos;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      in_raw   = 1'b0;
      in_eos   = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
      #1;
   endtask

   initial begin
      int base;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
      chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
      @(posedge clk);
      #1;

      // table of strings
      for (int v = 0; v < NV; v++) begin
         base = tot;
         for (int i = 0; i < V_LEN[v]; i++)
            beat(V_STR[v][8*(V_LEN[v]-1-i) +: 8], 1'b0, 1'b0);
         beat(8'h00, 1'b0, 1'b1);
         settle();
         chk(tot - base == V_NW[v], V_TAG[v], $sformatf("word count v%0d", v), tot - base, V_NW[v]);
         chk(cap_w[base % 64] == V_W0[v], V_TAG[v], $sformatf("word0 v%0d", v),
             cap_w[base % 64], V_W0[v]);
         chk(cap_e[base % 64] == V_E0[v], V_TAG[v], $sformatf("err0 v%0d", v),
             cap_e[base % 64], V_E0[v]);
         if (V_NW[v] == 2) begin
            chk(cap_w[(base+1) % 64] == V_W1[v], V_TAG[v], $sformatf("word1 v%0d", v),
                cap_w[(base+1) % 64], V_W1[v]);
            chk(cap_e[(base+1) % 64] == V_E1[v], V_TAG[v], $sformatf("err1 v%0d", v),
                cap_e[(base+1) % 64], V_E1[v]);
         end
         @(posedge clk);
         #1;
      end

      // R7: raw code 29 after A, B -> 3255 octal
      base = tot;
      beat("A", 1'b0, 1'b0);
      beat("B", 1'b0, 1'b0);
      beat(8'd29, 1'b1, 1'b0);
      beat(8'h00, 1'b0, 1'b1);
      settle();
      chk(tot - base == 1, "R7", "raw word count", tot - base, 1);
      chk(cap_w[base % 64] == 16'o3255, "R7", "raw 29 word", cap_w[base % 64], 16'o3255);
      chk(cap_e[base % 64] == 1'b0, "R7", "raw 29 err", cap_e[base % 64], 0);
      @(posedge clk);
      #1;

      // R7: raw code out of range
      base = tot;
      beat(8'd45, 1'b1, 1'b0);
      beat("B", 1'b0, 1'b0);
      beat(8'h00, 1'b0, 1'b1);
      settle();
      chk(cap_w[base % 64] == 16'h0050, "R7", "raw 45 word", cap_w[base % 64], 16'h0050);
      chk(cap_e[base % 64] == 1'b1, "R7", "raw 45 err", cap_e[base % 64], 1);
      @(posedge clk);
      #1;

      // R5: empty string
      base = tot;
      beat(8'h00, 1'b0, 1'b1);
      settle();
      chk(tot == base, "R5", "empty string words", tot - base, 0);
      @(posedge clk);
      #1;

      // R4: single char timing, word present just after the end beat
      beat("A", 1'b0, 1'b0);
      out_ready = 1'b0;
      beat(8'h00, 1'b0, 1'b1);
      @(negedge clk);
      chk(out_valid == 1'b1, "R4", "valid after end", out_valid, 1);
      chk(out_word == 16'h0640, "R4", "padded A", out_word, 16'h0640);
      out_ready = 1'b1;
      @(posedge clk);
      #1;

      // R3/R8: full group under backpressure
      out_ready = 1'b0;
      base = tot;
      beat("A", 1'b0, 1'b0);
      beat("B", 1'b0, 1'b0);
      beat("C", 1'b0, 1'b0);
      @(negedge clk);
      chk(out_valid == 1'b1, "R3", "valid after third code", out_valid, 1);
      chk(out_word == 16'h0693, "R3", "word after third code", out_word, 16'h0693);
      in_valid = 1'b1;
      in_data  = "D";
      repeat (3) @(negedge clk);
      chk(in_ready == 1'b0, "R8", "in_ready while stalled", in_ready, 0);
      chk(out_word == 16'h0693, "R8", "word held while stalled", out_word, 16'h0693);
      @(posedge clk);
      #1;
      out_ready = 1'b1;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      beat(8'h00, 1'b0, 1'b1);
      settle();
      chk(tot - base == 2, "R8", "words after stall", tot - base, 2);
      chk(cap_w[(base+1) % 64] == 16'h1900, "R8", "held char packed", cap_w[(base+1) % 64], 16'h1900);
      @(posedge clk);
      #1;

      // R9: reset discards a partial group
      base = tot;
      beat("A", 1'b0, 1'b0);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      beat("B", 1'b0, 1'b0);
      beat(8'h00, 1'b0, 1'b1);
      settle();
      chk(tot - base == 1, "R9", "words after mid reset", tot - base, 1);
      chk(cap_w[base % 64] == 16'h0C80, "R9", "group after reset", cap_w[base % 64], 16'h0C80);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule